// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus, intended to run from a 50 MHz clock. Software programs a reload value and a reset-pulse width. The countdown can be started or halted only by writing a matching pair of key words to the control register, so a stray single write cannot change whether the watchdog runs. Reading the reload-value address returns the live count, which lets software see how much time is left before expiry.

When a running count reaches zero, the block stops. It latches a watchdog bit in an interrupt status register and records a hardware-cause flag in a reset-cause register. It also drives a reset pulse whose width in clock ticks comes from a register. A software-reset register fires the same pulse on request and records its own cause flag. The pulse is an output only; whatever consumes it sits outside this block.

Register offsets (8-bit byte address): 0x24 interrupt status, 0x28 reload value / live count, 0x2C control keys, 0x30 pulse width, 0x34 software reset, 0x38 reset cause. Other addresses read as zero, and writes to them are ignored. Reads are combinational from the address.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, 0x28 reads DEF_INIT and the watchdog is not counting. 0x30 reads PULSE_INIT, 0x38 reads 0x8000_0000 (power-on flag in bit 31), and 0x24 and 0x2C read 0. Both the interrupt output and the pulse output are low.
- R2: A write of 0x0000_FF00 to 0x2C followed by a control write of 0x0000_00FF starts the countdown. From the clock edge of the second write onward, the live count drops by one every clock.
- R3: A write of 0x0000_EE00 to 0x2C followed by a control write of 0x0000_00EE halts the countdown and reloads the live count from the reload value. The first word of the pair alone changes nothing.
- R4: A control write that neither completes a key pair nor is a first key word disarms the key tracker and leaves the running state as it was. A first key word re-arms the tracker for its own pair. Writes to other addresses do not affect the tracker.
- R5: Reading 0x28 returns the live count, zero-extended to 32 bits.
- R6: While halted, a write to 0x28 sets both the reload value and the live count. While running, it sets only the reload value, and the countdown continues undisturbed until the next reload.
- R7: One clock after a running count reads zero, the block stops counting. It sets bit 4 of 0x24, which drives the interrupt output, sets bit 30 of 0x38, and raises the reset pulse.
- R8: The reset pulse stays high for W clocks, where W is the value in 0x30, or for one clock when that value is 0.
- R9: Bit 4 of 0x24 is cleared by writing 1 to it. Writing 0 to it has no effect. Bits 3:0 of 0x24 always read 0.
- R10: Writing a word with bit 0 set to 0x34 sets bit 29 of 0x38 and fires the reset pulse. A write with bit 0 clear has no effect.
- R11: Bits 31:28 of 0x38 are cleared individually by writing 1s to them. Bit 28 has no source and always reads 0.
- R12: Starting while halted with a live count of zero first reloads the live count from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (50 MHz in the system) |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_irq | output | 1 | Watchdog interrupt, mirrors bit 4 of 0x24 |
| wdt_rst_pulse | output | 1 | Stretched reset pulse |

## Verification
The bench builds the block with a 16-bit counter, an 8-bit pulse-width field, a power-up reload of 12 and a pulse width of 3. With these values every expiry is only a few clocks away, so the bench can sweep reload values 1 to 6 against pulse widths 0 to 4 in full. For each combination it follows the count value by value down to zero and measures the whole pulse. The small reload values also keep the key-abuse sequences, the halts during a run and the reload-while-running case well clear of an unintended expiry.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    // Register offsets: fixed, software and neighbouring decoders rely on them
    localparam logic [BUS_AW-1:0] A_IRQ    = 8'h24;
    localparam logic [BUS_AW-1:0] A_DEFCNT = 8'h28;
    localparam logic [BUS_AW-1:0] A_CTRL   = 8'h2C;
    localparam logic [BUS_AW-1:0] A_PLEN   = 8'h30;
    localparam logic [BUS_AW-1:0] A_SOFT   = 8'h34;
    localparam logic [BUS_AW-1:0] A_CAUSE  = 8'h38;

    // Key words compared against the full data word
    localparam logic [BUS_DW-1:0] KEY_RUN_A  = 32'h0000_FF00;
    localparam logic [BUS_DW-1:0] KEY_RUN_B  = 32'h0000_00FF;
    localparam logic [BUS_DW-1:0] KEY_HALT_A = 32'h0000_EE00;
    localparam logic [BUS_DW-1:0] KEY_HALT_B = 32'h0000_00EE;

    localparam int IRQ_WDT_BIT = 4;
    localparam int CAUSE_LSB   = 28;
    localparam int CAUSE_W     = 4;

    typedef enum logic [1:0] {
        KS_IDLE       = 2'd0,
        KS_RUN_ARMED  = 2'd1,
        KS_HALT_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic start;
        logic halt;
    } key_cmd_t;

    // Field order follows bits 31..28 of the cause register
    typedef struct packed {
        logic por;
        logic hw;
        logic sw;
        logic pcie;
    } cause_t;

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_wr_t;

    function automatic logic [BUS_DW-1:0] place_cause(input cause_t c);
        return {c, {CAUSE_LSB{1'b0}}};
    endfunction

    function automatic logic [BUS_DW-1:0] place_irq(input logic wdt);
        logic [BUS_DW-1:0] v;
        v = '0;
        v[IRQ_WDT_BIT] = wdt;
        return v;
    endfunction

    function automatic logic wr_hit(input bus_wr_t w, input logic [BUS_AW-1:0] a);
        return w.wr && (w.addr == a);
    endfunction

endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [BUS_DW-1:0] wdata,
    output key_cmd_t          cmd
);

    key_state_e state_q;
    key_state_e state_d;

    always_comb begin
        state_d = state_q;
        cmd     = '0;
        if (ctl_wr) begin
            state_d = KS_IDLE;
            if (state_q == KS_RUN_ARMED && wdata == KEY_RUN_B) begin
                cmd.start = 1'b1;
            end else if (state_q == KS_HALT_ARMED && wdata == KEY_HALT_B) begin
                cmd.halt = 1'b1;
            end else if (wdata == KEY_RUN_A) begin
                state_d = KS_RUN_ARMED;
            end else if (wdata == KEY_HALT_A) begin
                state_d = KS_HALT_ARMED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    AST_KEY_DISARM: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata != KEY_RUN_A && wdata != KEY_HALT_A) |=> (state_q == KS_IDLE)); // R4

    AST_KEY_START_ORDER: assert property (@(posedge clk) disable iff (rst)
        cmd.start |-> ($past(ctl_wr) || state_q == KS_RUN_ARMED)); // R2

endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown
    import kwd_pkg::*;
#(
    parameter int               CNT_W    = 32,
    parameter logic [CNT_W-1:0] DEF_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  key_cmd_t         cmd,
    input  logic             def_wr,
    input  logic [CNT_W-1:0] def_wdata,
    output logic [CNT_W-1:0] live_cnt,
    output logic             running,
    output logic             expire
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] def_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign live_cnt = cnt_q;
    assign running  = run_q;
    assign expire   = run_q && (cnt_q == '0) && !cmd.halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            def_q <= DEF_INIT;
            cnt_q <= DEF_INIT;
            run_q <= 1'b0;
        end else begin
            if (def_wr) begin
                def_q <= def_wdata;
            end
            if (cmd.halt) begin
                run_q <= 1'b0;
                cnt_q <= def_q;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    run_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - STEP;
                end
            end else if (cmd.start) begin
                run_q <= 1'b1;
                if (cnt_q == '0) begin
                    cnt_q <= def_q;
                end
            end else if (def_wr) begin
                cnt_q <= def_wdata;
            end
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != '0 && !cmd.halt) |=> (run_q && cnt_q == $past(cnt_q) - STEP)); // R2

    AST_HALT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> (!run_q && cnt_q == $past(def_q))); // R3

    AST_RUN_DEF_DEFER: assert property (@(posedge clk) disable iff (rst)
        (run_q && def_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - STEP)); // R6

    AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (rst)
        expire |=> (!run_q && cnt_q == '0)); // R7

    AST_ZERO_START: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && !run_q && cnt_q == '0) |=> (run_q && cnt_q == $past(def_q))); // R12

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int PULSE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic [PULSE_W-1:0] len,
    output logic               pulse_o
);

    localparam logic [PULSE_W-1:0] MIN_W = PULSE_W'(1);

    logic [PULSE_W-1:0] left_q;

    assign pulse_o = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trig) begin
            left_q <= (len == '0) ? MIN_W : len;
        end else if (left_q != '0) begin
            left_q <= left_q - MIN_W;
        end
    end

    AST_PULSE_SHRINK: assert property (@(posedge clk) disable iff (rst)
        (!trig && left_q != '0) |=> (left_q == $past(left_q) - MIN_W)); // R8

    AST_PULSE_RISE: assert property (@(posedge clk) disable iff (rst)
        trig |=> pulse_o); // R8

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int          PULSE_W    = 16,
    parameter int unsigned DEF_INIT   = 50_000_000,
    parameter int unsigned PULSE_INIT = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_irq,
    output logic        wdt_rst_pulse
);

    localparam logic [CNT_W-1:0]   DEF_INIT_V   = CNT_W'(DEF_INIT);
    localparam logic [PULSE_W-1:0] PLEN_INIT_V  = PULSE_W'(PULSE_INIT);
    localparam cause_t             CAUSE_RESET  = '{por: 1'b1, hw: 1'b0, sw: 1'b0, pcie: 1'b0};

    bus_wr_t            wr;
    key_cmd_t           key_cmd;
    logic               ctl_wr;
    logic [CNT_W-1:0]   live_cnt;
    logic               running;
    logic               expire;
    logic               soft_req;
    logic               irq_q;
    cause_t             cause_q;
    logic [CAUSE_W-1:0] cause_set;
    logic [CAUSE_W-1:0] cause_clr;
    logic [PULSE_W-1:0] plen_q;
    logic [BUS_DW-1:0]  cnt_ext;
    logic [BUS_DW-1:0]  plen_ext;

    assign wr       = '{wr: bus_we, addr: bus_addr, data: bus_wdata};
    assign ctl_wr   = wr_hit(wr, A_CTRL);
    assign soft_req = wr_hit(wr, A_SOFT) && wr.data[0];

    kwd_key_seq u_keys (
        .clk    (clk),
        .rst    (rst),
        .ctl_wr (ctl_wr),
        .wdata  (wr.data),
        .cmd    (key_cmd)
    );

    kwd_countdown #(
        .CNT_W    (CNT_W),
        .DEF_INIT (DEF_INIT_V)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .cmd       (key_cmd),
        .def_wr    (wr_hit(wr, A_DEFCNT)),
        .def_wdata (wr.data[CNT_W-1:0]),
        .live_cnt  (live_cnt),
        .running   (running),
        .expire    (expire)
    );

    kwd_pulse #(
        .PULSE_W (PULSE_W)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trig    (expire || soft_req),
        .len     (plen_q),
        .pulse_o (wdt_rst_pulse)
    );

    // Cause bits: set sources win over a clear in the same cycle
    assign cause_set = {1'b0, expire, soft_req, 1'b0};
    assign cause_clr = wr_hit(wr, A_CAUSE) ? wr.data[CAUSE_LSB +: CAUSE_W] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            cause_q <= CAUSE_RESET;
            plen_q  <= PLEN_INIT_V;
        end else begin
            irq_q   <= expire || (irq_q && !(wr_hit(wr, A_IRQ) && wr.data[IRQ_WDT_BIT]));
            cause_q <= cause_t'((cause_q & ~cause_clr) | cause_set);
            if (wr_hit(wr, A_PLEN)) begin
                plen_q <= wr.data[PULSE_W-1:0];
            end
        end
    end

    assign wdt_irq = irq_q;

    generate
        if (CNT_W >= BUS_DW) begin : g_cnt_full
            assign cnt_ext = live_cnt[BUS_DW-1:0];
        end else begin : g_cnt_pad
            assign cnt_ext = {{(BUS_DW-CNT_W){1'b0}}, live_cnt};
        end
        if (PULSE_W >= BUS_DW) begin : g_plen_full
            assign plen_ext = plen_q[BUS_DW-1:0];
        end else begin : g_plen_pad
            assign plen_ext = {{(BUS_DW-PULSE_W){1'b0}}, plen_q};
        end
    endgenerate

    always_comb begin
        unique case (bus_addr)
            A_IRQ:    bus_rdata = place_irq(irq_q);
            A_DEFCNT: bus_rdata = cnt_ext;
            A_PLEN:   bus_rdata = plen_ext;
            A_CAUSE:  bus_rdata = place_cause(cause_q);
            default:  bus_rdata = '0;
        endcase
    end

    AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        expire |=> (wdt_irq && cause_q.hw && wdt_rst_pulse)); // R7

    AST_IRQ_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_irq) |-> $past(bus_we && bus_addr == A_IRQ && bus_wdata[IRQ_WDT_BIT])); // R9

    AST_SOFT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        soft_req |=> (cause_q.sw && wdt_rst_pulse)); // R10

    AST_NONKEY_RUN: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !key_cmd.start && !key_cmd.halt && !expire) |=> (running == $past(running))); // R4

    AST_POR_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
        $fell(cause_q.por) |-> $past(bus_we && bus_addr == A_CAUSE && bus_wdata[31])); // R11

    AST_PCIE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cause_q.pcie); // R11

endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;

    localparam logic [7:0] A_IRQ    = 8'h24;
    localparam logic [7:0] A_DEFCNT = 8'h28;
    localparam logic [7:0] A_CTRL   = 8'h2C;
    localparam logic [7:0] A_PLEN   = 8'h30;
    localparam logic [7:0] A_SOFT   = 8'h34;
    localparam logic [7:0] A_CAUSE  = 8'h38;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq;
    logic        wdt_rst_pulse;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    keyed_watchdog #(
        .CNT_W      (16),
        .PULSE_W    (8),
        .DEF_INIT   (12),
        .PULSE_INIT (3)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .wdt_irq       (wdt_irq),
        .wdt_rst_pulse (wdt_rst_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic start_keys();
        wr(A_CTRL, 32'h0000_FF00);
        wr(A_CTRL, 32'h0000_00FF);
    endtask

    task automatic halt_keys();
        wr(A_CTRL, 32'h0000_EE00);
        wr(A_CTRL, 32'h0000_00EE);
    endtask

    // Two reads one clock apart; returns first and second live count
    task automatic two_counts(output logic [31:0] c1, output logic [31:0] c2);
        rd(A_DEFCNT, c1);
        @(negedge clk);
        rd(A_DEFCNT, c2);
    endtask

    task automatic pulse_width(output int w);
        w = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wdt_rst_pulse) w++;
            else break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c1;
        logic [31:0] c2;
        int          w;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_DEFCNT, v); check("R1 count after reset", v, 32'd12);
        rd(A_PLEN, v);   check("R1 pulse width after reset", v, 32'd3);
        rd(A_CAUSE, v);  check("R1 cause after reset", v, 32'h8000_0000);
        rd(A_IRQ, v);    check("R1 irq status after reset", v, 32'h0);
        rd(A_CTRL, v);   check("R1 control reads zero", v, 32'h0);
        check("R1 irq output low", {31'b0, wdt_irq}, 32'd0);
        check("R1 pulse output low", {31'b0, wdt_rst_pulse}, 32'd0);
        repeat (3) @(negedge clk);
        rd(A_DEFCNT, v); check("R1 not counting after reset", v, 32'd12);

        // R11 partial clears
        wr(A_CAUSE, 32'h4000_0000);
        rd(A_CAUSE, v);  check("R11 clear of unset bit keeps por", v, 32'h8000_0000);
        wr(A_CAUSE, 32'h8000_0000);
        rd(A_CAUSE, v);  check("R11 por cleared by one", v, 32'h0);

        // R4 key abuse while halted
        wr(A_DEFCNT, 32'd40);
        wr(A_CTRL, 32'h0000_FF00); wr(A_CTRL, 32'h0000_1234); wr(A_CTRL, 32'h0000_00FF);
        two_counts(c1, c2);
        check("R4 broken start pair c1", c1, 32'd40);
        check("R4 broken start pair c2", c2, 32'd40);
        wr(A_CTRL, 32'h0000_FF00); wr(A_CTRL, 32'h0000_EE00); wr(A_CTRL, 32'h0000_00FF);
        two_counts(c1, c2);
        check("R4 crossed keys no start", c2, 32'd40);
        // other-register write between keys does not disarm
        wr(A_CTRL, 32'h0000_FF00); wr(A_PLEN, 32'd3); wr(A_CTRL, 32'h0000_00FF);
        two_counts(c1, c2);
        check("R4 foreign write keeps arm, counting", c2, c1 - 1);
        halt_keys();
        rd(A_DEFCNT, v); check("R3 halt reloads", v, 32'd40);
        // repeated first key re-arms
        wr(A_CTRL, 32'h0000_FF00); wr(A_CTRL, 32'h0000_FF00); wr(A_CTRL, 32'h0000_00FF);
        two_counts(c1, c2);
        check("R4 re-armed start counts", c2, c1 - 1);
        // broken halt pair while running keeps running
        wr(A_CTRL, 32'h0000_EE00);
        two_counts(c1, c2);
        check("R3 first halt word alone keeps counting", c2, c1 - 1);
        wr(A_CTRL, 32'h0000_5555); wr(A_CTRL, 32'h0000_00EE);
        two_counts(c1, c2);
        check("R4 broken halt pair keeps counting", c2, c1 - 1);
        halt_keys();
        two_counts(c1, c2);
        check("R3 halted count reloaded", c1, 32'd40);
        check("R3 halted count stable", c2, 32'd40);

        // R6 reload value written while running
        start_keys();
        wr(A_DEFCNT, 32'd3);
        two_counts(c1, c2);
        check("R6 live count unaffected", {31'b0, (c1 > 32'd3)}, 32'd1);
        check("R6 countdown continues", c2, c1 - 1);
        halt_keys();
        rd(A_DEFCNT, v); check("R6 new value used at reload", v, 32'd3);

        // R2 R5 R7 R8 sweep
        for (int n = 1; n <= 6; n++) begin
            for (int l = 0; l <= 4; l++) begin
                wr(A_CAUSE, 32'hF000_0000);
                wr(A_IRQ, 32'h0000_0010);
                wr(A_PLEN, l);
                wr(A_DEFCNT, n);
                rd(A_DEFCNT, v); check("R6 halted write loads live", v, n);
                start_keys();
                for (int k = 0; k <= n; k++) begin
                    rd(A_DEFCNT, v);
                    check("R2 R5 live count step", v, n - k);
                    check("R7 no early irq", {31'b0, wdt_irq}, 32'd0);
                    @(negedge clk);
                end
                check("R7 irq raised", {31'b0, wdt_irq}, 32'd1);
                check("R7 pulse raised", {31'b0, wdt_rst_pulse}, 32'd1);
                rd(A_CAUSE, v);  check("R7 hw cause set", v, 32'h4000_0000);
                rd(A_IRQ, v);    check("R7 irq status bit4", v, 32'h0000_0010);
                rd(A_DEFCNT, v); check("R7 stopped at zero", v, 32'd0);
                pulse_width(w);
                check("R8 pulse width", w, (l == 0) ? 1 : l);
                rd(A_DEFCNT, v); check("R7 stays stopped", v, 32'd0);
            end
        end

        // R12 start from zero reloads
        start_keys();
        rd(A_DEFCNT, v); check("R12 start from zero reloads", v, 32'd6);
        halt_keys();

        // R9 irq write-one-to-clear
        wr(A_IRQ, 32'h0);
        check("R9 zero write keeps irq", {31'b0, wdt_irq}, 32'd1);
        wr(A_IRQ, 32'h0000_000F);
        check("R9 low bits write keeps irq", {31'b0, wdt_irq}, 32'd1);
        rd(A_IRQ, v); check("R9 low bits read zero", v, 32'h0000_0010);
        wr(A_IRQ, 32'h0000_0010);
        check("R9 irq cleared", {31'b0, wdt_irq}, 32'd0);
        rd(A_IRQ, v); check("R9 status cleared", v, 32'h0);

        // R10 software reset
        wr(A_CAUSE, 32'hF000_0000);
        wr(A_PLEN, 32'd5);
        wr(A_SOFT, 32'h0000_0002);
        check("R10 bit0 clear no pulse", {31'b0, wdt_rst_pulse}, 32'd0);
        rd(A_CAUSE, v); check("R10 bit0 clear no cause", v, 32'h0);
        wr(A_SOFT, 32'h0000_0001);
        check("R10 pulse fired", {31'b0, wdt_rst_pulse}, 32'd1);
        rd(A_CAUSE, v); check("R10 sw cause set", v, 32'h2000_0000);
        pulse_width(w);
        check("R10 R8 soft pulse width", w, 5);
        check("R10 no irq from soft reset", {31'b0, wdt_irq}, 32'd0);

        // R11 final clear and bit28
        wr(A_CAUSE, 32'h1000_0000);
        rd(A_CAUSE, v); check("R11 bit28 write leaves sw", v, 32'h2000_0000);
        wr(A_CAUSE, 32'h2000_0000);
        rd(A_CAUSE, v); check("R11 sw cleared", v, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule